// File: doc/BRIEF.md
# Split-Bank Physical Register File

This block holds the physical registers of an out-of-order core. A single physical index space spans two banks: integer entries occupy the low indices and floating-point entries follow directly after them, so the first floating-point index equals the integer entry count. Each bank has its own pair of read ports and its own write port. Every port carries a valid bit and a full physical index. The block decodes that index to decide whether it belongs to the bank the port serves, and it converts it to a local offset within that bank.

Reads are combinational. Writes take effect at the rising clock edge. The integer bank ignores writes to one designated zero register. The floating-point bank can do the same, but only when a parameter enables it. Floating-point words can be written either as numeric values or as raw bits. Both views land in the same storage. A raw-bit write is never dropped by the zero-register rule. A valid access whose index lies outside the bank it targets sets a sticky error flag and changes no storage.

Top module: `phys_regfile`

## Requirements
- R1: Index i < NUM_INT (default 64) selects integer entry i. Index NUM_INT <= i < NUM_INT+NUM_FP selects floating-point entry i-NUM_INT. Read data follows the index combinationally, and the two banks hold separate contents.
- R2: A write commits at the rising edge. A read of the same index in the write's own cycle returns the previous value, because there is no bypass.
- R3: An integer write to index ZERO_IDX (default 31) is discarded, so that entry always reads zero.
- R4: A numeric floating-point write (fp_wr_raw_i=0) to local offset ZERO_IDX (physical index NUM_INT+ZERO_IDX) is discarded only when FP_ZERO_DROP=1. With the default FP_ZERO_DROP=0 it is stored.
- R5: A raw-bit floating-point write (fp_wr_raw_i=1) is never discarded. Numeric and raw writes update the same word, and a read returns the stored bits unchanged.
- R6: While rst_ni is low, every entry of both banks is zero and err_o is 0.
- R7: A valid access outside its bank sets err_o at the next rising edge, and err_o stays set until reset. For an integer port this means an index >= NUM_INT. For a floating-point port it means an index < NUM_INT or >= NUM_INT+NUM_FP. An out-of-range write changes no entry.
- R8: A read port whose valid bit is low, or whose index is outside its bank, outputs zero.
- R9: The two read ports of a bank work independently and can read the same or different entries in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| int_rd_vld_i | input | NRD | Integer read port valid bits |
| int_rd_idx_i | input | NRD*IDX_W | Integer read physical indices |
| int_rd_data_o | output | NRD*DATA_W | Integer read data |
| int_wr_vld_i | input | 1 | Integer write valid |
| int_wr_idx_i | input | IDX_W | Integer write physical index |
| int_wr_data_i | input | DATA_W | Integer write data |
| fp_rd_vld_i | input | NRD | Floating-point read port valid bits |
| fp_rd_idx_i | input | NRD*IDX_W | Floating-point read physical indices |
| fp_rd_data_o | output | NRD*DATA_W | Floating-point read data |
| fp_wr_vld_i | input | 1 | Floating-point write valid |
| fp_wr_raw_i | input | 1 | 1 = raw-bit write, 0 = numeric write |
| fp_wr_idx_i | input | IDX_W | Floating-point write physical index |
| fp_wr_data_i | input | DATA_W | Floating-point write data |
| err_o | output | 1 | Sticky out-of-range access flag |

## Verification
The collision that matters is a write and a read of the same entry in one cycle. To provoke it, the bench drives both ports with the same index between two edges. It expects the read to return the old value before the edge and the new value after it. A second case puts a write and a read in the same cycle where the write is discarded, either by the zero-register rule or by the range check. The bench then reads the affected entry back through the normal read ports and expects it unchanged. The floating-point zero rule is checked on two instances, one with the drop enabled and one without, so that both parameter settings are judged on identical stimulus.

// File: rtl/prf_pkg.sv
package prf_pkg;
  function automatic int prf_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/prf_idx_decode.sv
module prf_idx_decode #(
  parameter int NUM_INT = 64,
  parameter int NUM_FP  = 64,
  parameter int IDX_W   = 7,
  parameter int IOFF_W  = 6,
  parameter int FOFF_W  = 6
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic              is_int_o,
  output logic              is_fp_o,
  output logic [IOFF_W-1:0] int_off_o,
  output logic [FOFF_W-1:0] fp_off_o
);
  localparam int BW = IDX_W + 1;
  localparam logic [BW-1:0] BASE  = BW'(NUM_INT);
  localparam logic [BW-1:0] TOTAL = BW'(NUM_INT + NUM_FP);
  localparam logic [IDX_W-1:0] BASE_N = IDX_W'(NUM_INT);

  logic [BW-1:0] ext;
  assign ext       = {1'b0, idx_i};
  assign is_int_o  = ext < BASE;
  assign is_fp_o   = (ext >= BASE) && (ext < TOTAL);
  assign int_off_o = idx_i[IOFF_W-1:0];
  // modular subtract; only meaningful when is_fp_o is set
  assign fp_off_o  = FOFF_W'(idx_i - BASE_N);
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int DEPTH     = 64,
  parameter int DATA_W    = 64,
  parameter int NRD       = 2,
  parameter int OFF_W     = 6,
  parameter int ZERO_IDX  = 31,
  parameter bit DROP_ZERO = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        exempt_i,
  input  logic [OFF_W-1:0]            wr_off_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic [NRD-1:0]              rd_en_i,
  input  logic [NRD-1:0][OFF_W-1:0]   rd_off_i,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data_o
);
  localparam logic [OFF_W-1:0] ZERO_OFF = OFF_W'(ZERO_IDX);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              drop;

  assign drop = DROP_ZERO && !exempt_i && (wr_off_i == ZERO_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < DEPTH; e++) mem_q[e] <= '0;
    end else if (we_i && !drop) begin
      mem_q[wr_off_i] <= wr_data_i;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = rd_en_i[r] ? mem_q[rd_off_i[r]] : '0;
  end
endmodule

// File: rtl/prf_err_track.sv
module prf_err_track #(
  parameter int NEV = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NEV-1:0] ev_i,
  output logic           err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_o <= 1'b0;
    else if (|ev_i)  err_o <= 1'b1;
  end
endmodule

// File: rtl/phys_regfile.sv
module phys_regfile
  import prf_pkg::*;
#(
  parameter int NUM_INT      = 64,
  parameter int NUM_FP       = 64,
  parameter int DATA_W       = 64,
  parameter int ZERO_IDX     = 31,
  parameter bit FP_ZERO_DROP = 1'b0,
  parameter int NRD          = 2,
  parameter int IDX_W        = prf_w(NUM_INT + NUM_FP)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NRD-1:0]             int_rd_vld_i,
  input  logic [NRD-1:0][IDX_W-1:0]  int_rd_idx_i,
  output logic [NRD-1:0][DATA_W-1:0] int_rd_data_o,
  input  logic                       int_wr_vld_i,
  input  logic [IDX_W-1:0]           int_wr_idx_i,
  input  logic [DATA_W-1:0]          int_wr_data_i,
  input  logic [NRD-1:0]             fp_rd_vld_i,
  input  logic [NRD-1:0][IDX_W-1:0]  fp_rd_idx_i,
  output logic [NRD-1:0][DATA_W-1:0] fp_rd_data_o,
  input  logic                       fp_wr_vld_i,
  input  logic                       fp_wr_raw_i,
  input  logic [IDX_W-1:0]           fp_wr_idx_i,
  input  logic [DATA_W-1:0]          fp_wr_data_i,
  output logic                       err_o
);
  localparam int IOFF_W = prf_w(NUM_INT);
  localparam int FOFF_W = prf_w(NUM_FP);
  localparam int NEV    = 2 * NRD + 2;

  logic [NRD-1:0]             ird_in, frd_in, ird_en, frd_en;
  logic [NRD-1:0]             ird_fp_unused, frd_int_unused;
  logic [NRD-1:0][IOFF_W-1:0] ird_off, frd_ioff_unused;
  logic [NRD-1:0][FOFF_W-1:0] frd_off, ird_foff_unused;
  logic                       iwr_in, fwr_in, iwr_fp_unused, fwr_int_unused;
  logic [IOFF_W-1:0]          iwr_off, fwr_ioff_unused;
  logic [FOFF_W-1:0]          fwr_off, iwr_foff_unused;
  logic [NEV-1:0]             oor_ev;

  for (genvar r = 0; r < NRD; r++) begin : g_rdp
    prf_idx_decode #(
      .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W),
      .IOFF_W(IOFF_W), .FOFF_W(FOFF_W)
    ) u_idec (
      .idx_i    (int_rd_idx_i[r]),
      .is_int_o (ird_in[r]),
      .is_fp_o  (ird_fp_unused[r]),
      .int_off_o(ird_off[r]),
      .fp_off_o (ird_foff_unused[r])
    );
    prf_idx_decode #(
      .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W),
      .IOFF_W(IOFF_W), .FOFF_W(FOFF_W)
    ) u_fdec (
      .idx_i    (fp_rd_idx_i[r]),
      .is_int_o (frd_int_unused[r]),
      .is_fp_o  (frd_in[r]),
      .int_off_o(frd_ioff_unused[r]),
      .fp_off_o (frd_off[r])
    );
    assign ird_en[r]        = int_rd_vld_i[r] && ird_in[r];
    assign frd_en[r]        = fp_rd_vld_i[r] && frd_in[r];
    assign oor_ev[r]        = int_rd_vld_i[r] && !ird_in[r];
    assign oor_ev[NRD + r]  = fp_rd_vld_i[r] && !frd_in[r];
  end

  prf_idx_decode #(
    .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W),
    .IOFF_W(IOFF_W), .FOFF_W(FOFF_W)
  ) u_iwdec (
    .idx_i    (int_wr_idx_i),
    .is_int_o (iwr_in),
    .is_fp_o  (iwr_fp_unused),
    .int_off_o(iwr_off),
    .fp_off_o (iwr_foff_unused)
  );

  prf_idx_decode #(
    .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IDX_W(IDX_W),
    .IOFF_W(IOFF_W), .FOFF_W(FOFF_W)
  ) u_fwdec (
    .idx_i    (fp_wr_idx_i),
    .is_int_o (fwr_int_unused),
    .is_fp_o  (fwr_in),
    .int_off_o(fwr_ioff_unused),
    .fp_off_o (fwr_off)
  );

  assign oor_ev[2*NRD]     = int_wr_vld_i && !iwr_in;
  assign oor_ev[2*NRD + 1] = fp_wr_vld_i && !fwr_in;

  prf_bank #(
    .DEPTH(NUM_INT), .DATA_W(DATA_W), .NRD(NRD), .OFF_W(IOFF_W),
    .ZERO_IDX(ZERO_IDX), .DROP_ZERO(1'b1)
  ) u_int_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (int_wr_vld_i && iwr_in),
    .exempt_i (1'b0),
    .wr_off_i (iwr_off),
    .wr_data_i(int_wr_data_i),
    .rd_en_i  (ird_en),
    .rd_off_i (ird_off),
    .rd_data_o(int_rd_data_o)
  );

  prf_bank #(
    .DEPTH(NUM_FP), .DATA_W(DATA_W), .NRD(NRD), .OFF_W(FOFF_W),
    .ZERO_IDX(ZERO_IDX), .DROP_ZERO(FP_ZERO_DROP)
  ) u_fp_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (fp_wr_vld_i && fwr_in),
    .exempt_i (fp_wr_raw_i),
    .wr_off_i (fwr_off),
    .wr_data_i(fp_wr_data_i),
    .rd_en_i  (frd_en),
    .rd_off_i (frd_off),
    .rd_data_o(fp_rd_data_o)
  );

  prf_err_track #(.NEV(NEV)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (oor_ev),
    .err_o (err_o)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int NUM_INT  = 64,
  parameter int NUM_FP   = 64,
  parameter int DATA_W   = 64,
  parameter int ZERO_IDX = 31,
  parameter int NRD      = 2,
  parameter int IDX_W    = 7
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NRD-1:0]             int_rd_vld_i,
  input logic [NRD-1:0][IDX_W-1:0]  int_rd_idx_i,
  input logic [NRD-1:0][DATA_W-1:0] int_rd_data_o,
  input logic                       int_wr_vld_i,
  input logic [IDX_W-1:0]           int_wr_idx_i,
  input logic [DATA_W-1:0]          int_wr_data_i,
  input logic [NRD-1:0]             fp_rd_vld_i,
  input logic [NRD-1:0][IDX_W-1:0]  fp_rd_idx_i,
  input logic                       fp_wr_vld_i,
  input logic [IDX_W-1:0]           fp_wr_idx_i,
  input logic                       err_o
);
  localparam int BW = IDX_W + 1;
  localparam logic [BW-1:0] BASE_C  = BW'(NUM_INT);
  localparam logic [BW-1:0] TOTAL_C = BW'(NUM_INT + NUM_FP);
  localparam logic [IDX_W-1:0] ZERO_C = IDX_W'(ZERO_IDX);

  logic oor_any, iwr_ok;
  always_comb begin
    oor_any = 1'b0;
    for (int r = 0; r < NRD; r++) begin
      if (int_rd_vld_i[r] && ({1'b0, int_rd_idx_i[r]} >= BASE_C)) oor_any = 1'b1;
      if (fp_rd_vld_i[r] && (({1'b0, fp_rd_idx_i[r]} < BASE_C) ||
                             ({1'b0, fp_rd_idx_i[r]} >= TOTAL_C))) oor_any = 1'b1;
    end
    if (int_wr_vld_i && ({1'b0, int_wr_idx_i} >= BASE_C)) oor_any = 1'b1;
    if (fp_wr_vld_i && (({1'b0, fp_wr_idx_i} < BASE_C) ||
                        ({1'b0, fp_wr_idx_i} >= TOTAL_C))) oor_any = 1'b1;
  end
  assign iwr_ok = int_wr_vld_i && ({1'b0, int_wr_idx_i} < BASE_C) && (int_wr_idx_i != ZERO_C);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_err_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(oor_any));
  p_oor_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_any |=> err_o);
  p_zero_reads_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rd_vld_i[0] && int_rd_idx_i[0] == ZERO_C) |-> int_rd_data_o[0] == '0);
  p_idle_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_rd_vld_i[0] |-> int_rd_data_o[0] == '0);
  p_write_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(iwr_ok) && int_rd_vld_i[0] && int_rd_idx_i[0] == $past(int_wr_idx_i))
      |-> int_rd_data_o[0] == $past(int_wr_data_i));
endmodule

bind phys_regfile prf_checker #(
  .NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .DATA_W(DATA_W),
  .ZERO_IDX(ZERO_IDX), .NRD(NRD), .IDX_W(IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .int_rd_vld_i (int_rd_vld_i),
  .int_rd_idx_i (int_rd_idx_i),
  .int_rd_data_o(int_rd_data_o),
  .int_wr_vld_i (int_wr_vld_i),
  .int_wr_idx_i (int_wr_idx_i),
  .int_wr_data_i(int_wr_data_i),
  .fp_rd_vld_i  (fp_rd_vld_i),
  .fp_rd_idx_i  (fp_rd_idx_i),
  .fp_wr_vld_i  (fp_wr_vld_i),
  .fp_wr_idx_i  (fp_wr_idx_i),
  .err_o        (err_o)
);

// File: tb/sim_phys_regfile.sv
`timescale 1ns/1ps
module sim_phys_regfile;
  localparam int IW = 7;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]         ird_vld, frd_vld;
  logic [1:0][IW-1:0] ird_idx, frd_idx;
  logic [1:0][DW-1:0] ird_d0, frd_d0, ird_d1, frd_d1;
  logic               iwr_vld, fwr_vld, fwr_raw;
  logic [IW-1:0]      iwr_idx, fwr_idx;
  logic [DW-1:0]      iwr_dat, fwr_dat;
  logic               err0, err1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  phys_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .int_rd_vld_i(ird_vld), .int_rd_idx_i(ird_idx), .int_rd_data_o(ird_d0),
    .int_wr_vld_i(iwr_vld), .int_wr_idx_i(iwr_idx), .int_wr_data_i(iwr_dat),
    .fp_rd_vld_i(frd_vld), .fp_rd_idx_i(frd_idx), .fp_rd_data_o(frd_d0),
    .fp_wr_vld_i(fwr_vld), .fp_wr_raw_i(fwr_raw), .fp_wr_idx_i(fwr_idx),
    .fp_wr_data_i(fwr_dat), .err_o(err0)
  );

  phys_regfile #(.FP_ZERO_DROP(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .int_rd_vld_i(ird_vld), .int_rd_idx_i(ird_idx), .int_rd_data_o(ird_d1),
    .int_wr_vld_i(iwr_vld), .int_wr_idx_i(iwr_idx), .int_wr_data_i(iwr_dat),
    .fp_rd_vld_i(frd_vld), .fp_rd_idx_i(frd_idx), .fp_rd_data_o(frd_d1),
    .fp_wr_vld_i(fwr_vld), .fp_wr_raw_i(fwr_raw), .fp_wr_idx_i(fwr_idx),
    .fp_wr_data_i(fwr_dat), .err_o(err1)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    ird_vld = '0; frd_vld = '0; ird_idx = '0; frd_idx = '0;
    iwr_vld = 0; fwr_vld = 0; fwr_raw = 0;
    iwr_idx = '0; fwr_idx = '0; iwr_dat = '0; fwr_dat = '0;
  endtask

  task automatic int_wr(input logic [IW-1:0] idx, input logic [DW-1:0] d);
    @(negedge clk);
    iwr_vld = 1; iwr_idx = idx; iwr_dat = d;
    @(posedge clk); #1 iwr_vld = 0;
  endtask

  task automatic fp_wr(input logic [IW-1:0] idx, input bit raw, input logic [DW-1:0] d);
    @(negedge clk);
    fwr_vld = 1; fwr_raw = raw; fwr_idx = idx; fwr_dat = d;
    @(posedge clk); #1 fwr_vld = 0; fwr_raw = 0;
  endtask

  task automatic int_rd(input int p, input logic [IW-1:0] idx, input logic [DW-1:0] exp,
                        input string req);
    @(negedge clk);
    ird_vld[p] = 1; ird_idx[p] = idx;
    #1 chk(ird_d0[p] === exp, req, ird_d0[p], exp);
    ird_vld[p] = 0;
  endtask

  task automatic fp_rd(input int p, input logic [IW-1:0] idx, input logic [DW-1:0] exp0,
                       input logic [DW-1:0] exp1, input string req);
    @(negedge clk);
    frd_vld[p] = 1; frd_idx[p] = idx;
    #1;
    chk(frd_d0[p] === exp0, req, frd_d0[p], exp0);
    chk(frd_d1[p] === exp1, req, frd_d1[p], exp1);
    frd_vld[p] = 0;
  endtask

  task automatic t_reset_state();
    // R6: all entries zero and no error while in reset
    ird_vld = 2'b11; ird_idx[0] = 7'd0; ird_idx[1] = 7'd63;
    frd_vld = 2'b11; frd_idx[0] = 7'd64; frd_idx[1] = 7'd127;
    #1;
    chk(ird_d0[0] === '0 && ird_d0[1] === '0, "R6 int reset", ird_d0[0] | ird_d0[1], '0);
    chk(frd_d0[0] === '0 && frd_d0[1] === '0, "R6 fp reset", frd_d0[0] | frd_d0[1], '0);
    chk(err0 === 1'b0, "R6 err reset", 64'(err0), '0);
    idle();
  endtask

  task automatic t_int_rw();
    // R2: same-cycle read returns old contents
    @(negedge clk);
    iwr_vld = 1; iwr_idx = 7'd5; iwr_dat = 64'hA5A5_0000_1234_5678;
    ird_vld[0] = 1; ird_idx[0] = 7'd5;
    #1 chk(ird_d0[0] === '0, "R2 no bypass", ird_d0[0], '0);
    @(posedge clk); #1 iwr_vld = 0;
    chk(ird_d0[0] === 64'hA5A5_0000_1234_5678, "R2 visible after edge",
        ird_d0[0], 64'hA5A5_0000_1234_5678);
    ird_vld[0] = 0;
    // R9: both ports, same and different entries
    int_wr(7'd63, 64'hBEEF);
    @(negedge clk);
    ird_vld = 2'b11; ird_idx[0] = 7'd5; ird_idx[1] = 7'd5;
    #1 chk(ird_d0[0] === ird_d0[1] && ird_d0[1] === 64'hA5A5_0000_1234_5678,
           "R9 same entry", ird_d0[1], 64'hA5A5_0000_1234_5678);
    ird_idx[1] = 7'd63;
    #1 chk(ird_d0[1] === 64'hBEEF && ird_d0[0] === 64'hA5A5_0000_1234_5678,
           "R9 different entries", ird_d0[1], 64'hBEEF);
    ird_vld = '0;
    // R1: fp index 64 is fp entry 0, separate from int entry 0
    fp_wr(7'd64, 1'b0, 64'hC0C0);
    fp_rd(1, 7'd64, 64'hC0C0, 64'hC0C0, "R1 fp base entry");
    int_rd(0, 7'd0, '0, "R1 int entry 0 untouched");
    fp_rd(0, 7'd127, '0, '0, "R1 fp top entry empty");
  endtask

  task automatic t_int_zero();
    int_wr(7'd31, '1);
    int_rd(1, 7'd31, '0, "R3 zero reg ignored");
    int_wr(7'd30, 64'h30);
    int_rd(0, 7'd30, 64'h30, "R3 neighbour written");
  endtask

  task automatic t_fp_zero();
    // R4: fp local offset 31 = physical 95; u0 keeps, u1 drops
    fp_wr(7'd95, 1'b0, 64'hD00D);
    fp_rd(0, 7'd95, 64'hD00D, '0, "R4 numeric zero-offset write");
  endtask

  task automatic t_fp_raw();
    fp_wr(7'd95, 1'b1, 64'h7FF8_0000_0000_0001);
    fp_rd(1, 7'd95, 64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0001, "R5 raw never dropped");
    fp_wr(7'd96, 1'b1, 64'h1111);
    fp_wr(7'd96, 1'b0, 64'h4000_0000_0000_0000);
    fp_rd(0, 7'd96, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000, "R5 shared word");
  endtask

  task automatic t_idle_read();
    @(negedge clk);
    ird_vld[0] = 0; ird_idx[0] = 7'd5;
    #1 chk(ird_d0[0] === '0, "R8 invalid port reads zero", ird_d0[0], '0);
    chk(err0 === 1'b0, "R8 invalid port raises no error", 64'(err0), '0);
  endtask

  task automatic t_range_err();
    @(negedge clk);
    ird_vld[0] = 1; ird_idx[0] = 7'd64;
    #1 chk(ird_d0[0] === '0, "R8 out-of-bank int read zero", ird_d0[0], '0);
    chk(err0 === 1'b0, "R7 err not before edge", 64'(err0), '0);
    @(posedge clk); #1 ird_vld[0] = 0;
    chk(err0 === 1'b1, "R7 err after int oor read", 64'(err0), 1);
    fp_rd(0, 7'd10, '0, '0, "R8 out-of-bank fp read zero");
    // oor writes: int 70 would alias offset 6, fp 10 would alias fp 74
    int_wr(7'd70, 64'hDEAD);
    fp_wr(7'd10, 1'b1, 64'hDEAD);
    int_rd(0, 7'd6, '0, "R7 oor int write no effect");
    fp_rd(1, 7'd74, '0, '0, "R7 oor fp write no effect");
    repeat (3) @(posedge clk);
    #1 chk(err0 === 1'b1, "R7 err sticky", 64'(err0), 1);
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 0;
    #1;
    ird_vld = 2'b01; ird_idx[0] = 7'd5;
    frd_vld = 2'b01; frd_idx[0] = 7'd96;
    #0.5;
    chk(ird_d0[0] === '0 && frd_d0[0] === '0, "R6 entries cleared",
        ird_d0[0] | frd_d0[0], '0);
    chk(err0 === 1'b0, "R6 err cleared", 64'(err0), '0);
    idle();
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    idle();
    #1 t_reset_state();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_int_rw();
    t_int_zero();
    t_fp_zero();
    t_fp_raw();
    t_idle_read();
    t_range_err();
    t_reset_again();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule